// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block decides which of several interrupt request lines an 8-bit core should service next. Each source has its own enable bit and its own level bit, which places it at low or high priority. A master enable gates every source at once. The controller records which priority levels have a handler running. It raises a vector request only when the best pending source sits at a level above everything currently in service.

When it raises a request, the controller presents the winning source index, that source's level and its call target address. It keeps all of these steady until the core acknowledges the start of the call. The acknowledge marks the winner's level as in service. The return-from-interrupt strobe at the end of a handler releases the highest level still marked.

Ties are broken in two steps. A high-level request beats a low-level one. Within one level, the lowest source index wins.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, `vec_req` is 0 and both `in_svc` bits are 0.
- R2: A source whose `src_en` bit is 0 never produces a vector request, whatever its request line does.
- R3: With `master_en` at 0, no vector request is raised, even when enabled sources are requesting.
- R4: When high-level and low-level enabled sources request together, the granted source is a high-level one (`src_hi` bit 1 = high, 0 = low) and `vec_hi` is 1.
- R5: Among enabled requesters of the winning level, the lowest source index is granted.
- R6: `vec_addr` equals 0x0003 + 8 × `vec_src` while `vec_req` is 1.
- R7: A high-level request is issued while only a low-level handler is in service (`in_svc` = 2'b01).
- R8: A low-level request is not issued while any handler is in service (`in_svc` ≠ 0).
- R9: No request of either level is issued while a high-level handler is in service (`in_svc[1]` = 1).
- R10: Once `vec_req` is 1, it stays 1 with the same `vec_src`, `vec_hi` and `vec_addr` until `ack` is seen, even if the request lines change.
- R11: `ack` while `vec_req` is 1 sets `in_svc[vec_hi]` and drops `vec_req` on the next cycle. A new grant is evaluated no earlier than the cycle after that.
- R12: A `reti` pulse clears `in_svc[1]` if it is set, otherwise `in_svc[0]`. With neither set it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Request lines, one per source |
| src_en | input | NUM_SRC | Per-source enable |
| src_hi | input | NUM_SRC | Per-source level, 1 = high |
| master_en | input | 1 | Global enable for all sources |
| ack | input | 1 | Core has started the call for the presented vector |
| reti | input | 1 | Handler finished, one-cycle pulse |
| vec_req | output | 1 | Vector request to the core |
| vec_src | output | IDX_W | Granted source index |
| vec_hi | output | 1 | Level of the granted source |
| vec_addr | output | VEC_W | Call target of the granted source |
| in_svc | output | 2 | In-service flags, bit 1 high level, bit 0 low level |

## Verification
On every cycle, the assertions check three things. The presented vector is held steady until acknowledge. The request drops right after acknowledge. No request appears while a high-level handler runs, or for a low-level source while any handler runs. The polling grant must also always be one-hot and agree with the chosen index. The correct choice among simultaneous requesters, the masking by enables, the address arithmetic and the nesting sequence of acknowledges and returns depend on the history of inputs. These are shown only by the bench's directed scenarios and by its per-cycle comparison against a behavioural model under random traffic.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;

  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_src_mask.sv
module irq_src_mask #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_hi,
  input  logic               master_en,
  output logic [NUM_SRC-1:0] pend_hi,
  output logic [NUM_SRC-1:0] pend_lo
);
  logic [NUM_SRC-1:0] live;

  always_comb begin
    live    = irq_req & src_en & {NUM_SRC{master_en}};
    pend_hi = live & src_hi;
    pend_lo = live & ~src_hi;
  end
endmodule

// File: rtl/irq_poll_pick.sv
module irq_poll_pick import irq_nest_pkg::*; #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] grant
);
  // lowest index takes precedence: scan downward, last hit wins
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    grant = pend & ~(pend - NUM_SRC'(1));
    any   = |pend;
  end

  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_grant_idx_r5: assert property (@(posedge clk) disable iff (rst)
    any |-> grant[idx]);
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track import irq_nest_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     set_en,
  input  irq_lvl_e set_lvl,
  input  logic     reti,
  output logic     may_hi,
  output logic     may_lo,
  output logic [1:0] svc
);
  logic [1:0] svc_q;
  logic [1:0] svc_d;

  always_comb begin
    svc_d = svc_q;
    if (reti) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (set_en) svc_d[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) svc_q <= 2'b00;
    else     svc_q <= svc_d;
  end

  always_comb begin
    may_hi = ~svc_q[1];
    may_lo = ~svc_q[1] & ~svc_q[0];
    svc    = svc_q;
  end

  p_reti_hi_first_r12: assert property (@(posedge clk) disable iff (rst)
    (reti && svc_q[1] && !set_en) |=> (!svc_q[1] && svc_q[0] == $past(svc_q[0])));
  p_reti_lo_r12: assert property (@(posedge clk) disable iff (rst)
    (reti && !svc_q[1] && !set_en) |=> (svc_q == 2'b00));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl import irq_nest_pkg::*; #(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_hi,
  input  logic               master_en,
  input  logic               ack,
  input  logic               reti,
  output logic               vec_req,
  output logic [IDX_W-1:0]   vec_src,
  output logic               vec_hi,
  output logic [VEC_W-1:0]   vec_addr,
  output logic [1:0]         in_svc
);
  logic [NUM_SRC-1:0] pend_hi, pend_lo, gnt_hi, gnt_lo;
  logic               any_hi, any_lo;
  logic [IDX_W-1:0]   idx_hi, idx_lo;
  logic               may_hi, may_lo;

  irq_src_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .irq_req(irq_req), .src_en(src_en), .src_hi(src_hi),
    .master_en(master_en), .pend_hi(pend_hi), .pend_lo(pend_lo)
  );

  irq_poll_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick_hi (
    .clk(clk), .rst(rst), .pend(pend_hi), .any(any_hi), .idx(idx_hi), .grant(gnt_hi)
  );

  irq_poll_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick_lo (
    .clk(clk), .rst(rst), .pend(pend_lo), .any(any_lo), .idx(idx_lo), .grant(gnt_lo)
  );

  logic     req_q, lvl_q;
  logic [IDX_W-1:0] src_q;
  logic [VEC_W-1:0] addr_q;
  logic     take, ack_ok;
  irq_lvl_e win_lvl;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    win_lvl = any_hi ? LVL_HI : LVL_LO;
    win_idx = any_hi ? idx_hi : idx_lo;
    ack_ok  = req_q & ack;
    take    = ~req_q & (any_hi ? may_hi : (any_lo & may_lo));
  end

  irq_svc_track u_track (
    .clk(clk), .rst(rst), .set_en(ack_ok), .set_lvl(irq_lvl_e'(lvl_q)),
    .reti(reti), .may_hi(may_hi), .may_lo(may_lo), .svc(in_svc)
  );

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] i);
    return VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      lvl_q  <= 1'b0;
      src_q  <= '0;
      addr_q <= '0;
    end else if (ack_ok) begin
      req_q <= 1'b0;
    end else if (take) begin
      req_q  <= 1'b1;
      lvl_q  <= win_lvl;
      src_q  <= win_idx;
      addr_q <= vec_of(win_idx);
    end
  end

  always_comb begin
    vec_req  = req_q;
    vec_src  = src_q;
    vec_hi   = lvl_q;
    vec_addr = addr_q;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !ack) |=> (vec_req && $stable(vec_src) && $stable(vec_hi) && $stable(vec_addr)));
  p_ack_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (vec_req && ack) |=> !vec_req);
  p_hi_block_r9: assert property (@(posedge clk) disable iff (rst)
    in_svc[1] |-> !vec_req);
  p_lo_nest_r8: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !vec_hi) |-> (in_svc == 2'b00));
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_req = '0, src_en = '0, src_hi = '0;
  logic master_en = 1'b0, ack = 1'b0, reti = 1'b0;
  logic vec_req, vec_hi;
  logic [IW-1:0] vec_src;
  logic [15:0] vec_addr;
  logic [1:0] in_svc;

  always #10 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .src_en(src_en), .src_hi(src_hi),
    .master_en(master_en), .ack(ack), .reti(reti), .vec_req(vec_req),
    .vec_src(vec_src), .vec_hi(vec_hi), .vec_addr(vec_addr), .in_svc(in_svc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_req = 0, m_src = 0, m_lvl = 0;
  int m_ins[2] = '{0, 0};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int ins_n[2];
    int found, w, wl;
    if (rst) begin
      m_req = 0; m_src = 0; m_lvl = 0; m_ins[0] = 0; m_ins[1] = 0;
      return;
    end
    ins_n[0] = m_ins[0]; ins_n[1] = m_ins[1];
    if (reti) begin
      if (m_ins[1] != 0) ins_n[1] = 0; else ins_n[0] = 0;
    end
    if (m_req != 0 && ack) begin
      ins_n[m_lvl] = 1;
      m_req = 0;
    end else if (m_req == 0) begin
      found = 0; w = 0; wl = 0;
      for (int lv = 1; lv >= 0 && found == 0; lv--)
        for (int i = 0; i < N && found == 0; i++)
          if (irq_req[i] && src_en[i] && master_en && (int'(src_hi[i]) == lv)) begin
            found = 1; w = i; wl = lv;
          end
      if (found != 0 && ((wl == 1) ? (m_ins[1] == 0) : (m_ins[0] == 0 && m_ins[1] == 0))) begin
        m_req = 1; m_src = w; m_lvl = wl;
      end
    end
    m_ins[0] = ins_n[0]; m_ins[1] = ins_n[1];
  endtask

  // one clock: model follows the applied inputs, then outputs compared mid-cycle
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R10 vec_req vs model", int'(vec_req), m_req);
    chk("R12 in_svc vs model", int'(in_svc), m_ins[1] * 2 + m_ins[0]);
    if (m_req != 0) begin
      chk("R5 vec_src vs model", int'(vec_src), m_src);
      chk("R4 vec_hi vs model", int'(vec_hi), m_lvl);
      chk("R6 vec_addr vs model", int'(vec_addr), 3 + 8 * m_src);
    end
  endtask

  task automatic idle_in();
    irq_req = '0; ack = 0; reti = 0;
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    cyc(); cyc();
    rst = 0;
    chk("R1 reset vec_req", int'(vec_req), 0);
    chk("R1 reset in_svc", int'(in_svc), 0);

    // R2: disabled source ignored
    master_en = 1; src_en = 8'h00; irq_req = 8'h01;
    cyc(); cyc();
    chk("R2 disabled source", int'(vec_req), 0);

    // R3: master enable off
    master_en = 0; src_en = 8'hFF; irq_req = 8'hFF;
    cyc(); cyc();
    chk("R3 master off", int'(vec_req), 0);

    // R4: high beats low
    master_en = 1; src_hi = 8'h80; irq_req = 8'h81;
    cyc();
    chk("R4 grant req", int'(vec_req), 1);
    chk("R4 grant src", int'(vec_src), 7);
    chk("R4 grant level", int'(vec_hi), 1);
    ack = 1; cyc(); ack = 0;
    chk("R11 in_svc after ack", int'(in_svc), 2);
    chk("R11 drop after ack", int'(vec_req), 0);
    idle_in(); reti = 1; cyc(); reti = 0;
    chk("R12 reti clears high", int'(in_svc), 0);

    // R5/R6: same level ties
    src_hi = 8'h00; irq_req = 8'h0C;
    cyc();
    chk("R5 lowest index", int'(vec_src), 2);
    chk("R6 address", int'(vec_addr), 16'h0013);
    ack = 1; cyc(); ack = 0;
    chk("R11 low in service", int'(in_svc), 1);

    // R8: low cannot nest on low
    irq_req = 8'h08;
    cyc(); cyc(); cyc();
    chk("R8 low blocked", int'(vec_req), 0);

    // R7: high preempts low
    src_hi = 8'h20; irq_req = 8'h28;
    cyc();
    chk("R7 high preempts", int'(vec_req), 1);
    chk("R7 src", int'(vec_src), 5);
    chk("R6 address src5", int'(vec_addr), 16'h002B);
    ack = 1; cyc(); ack = 0;
    chk("R11 both in service", int'(in_svc), 3);

    // R9: nothing preempts high
    src_hi = 8'hFF; irq_req = 8'hFF;
    cyc(); cyc();
    chk("R9 high blocks all", int'(vec_req), 0);
    idle_in(); reti = 1; cyc();
    chk("R12 reti clears high first", int'(in_svc), 1);
    cyc(); reti = 0;
    chk("R12 second reti clears low", int'(in_svc), 0);
    reti = 1; cyc(); reti = 0;
    chk("R12 reti with none set", int'(in_svc), 0);

    // R10: hold until ack
    src_hi = 8'h00; irq_req = 8'h10;
    cyc();
    chk("R10 issued", int'(vec_src), 4);
    irq_req = 8'h00; cyc();
    src_hi = 8'h01; irq_req = 8'h01; cyc(); cyc();
    chk("R10 still held", int'(vec_req), 1);
    chk("R10 same src", int'(vec_src), 4);
    ack = 1; cyc(); ack = 0; idle_in();
    reti = 1; cyc(); reti = 0;

    // random traffic compared each cycle
    for (int k = 0; k < 4000; k++) begin
      irq_req   = N'($urandom);
      src_en    = N'($urandom) | N'($urandom);
      src_hi    = N'($urandom);
      master_en = ($urandom % 8) != 0;
      ack       = ($urandom % 3) == 0;
      reti      = (($urandom % 5) == 0);
      cyc();
    end
    idle_in();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule